// File: doc/BRIEF.md
# Watchdog Timer with Guarded Turn-Off

This block is a watchdog for a system-clock domain. A counter advances by one on each cycle in which the tick input is high. It advances only while the watchdog is switched on. When the count reaches a limit chosen by a three-bit prescale code, the block raises a reset request. Software holds the reset off by pulsing a restart input, which sets the count back to zero.

Software reaches the block through a five-bit control write port, and the register contents can be read back at all times. Switching the watchdog on is always allowed. Switching it off is guarded. First, one write must set the turn-off-enable bit and the enable bit together. A later write that clears the enable bit then takes effect only if it lands within a short window of system clocks after that first write.

The count is kept while the watchdog is off. If software switches the watchdog back on without a restart, counting resumes from the old value. The tick is assumed to be synchronous to the system clock already, and to last one cycle.

Top module: `wdog_top`

## Requirements
- R1: After reset, `cfg_rdata` reads 0, `reset_req` is low and the count is zero.
- R2: While enabled, the timeout is `2^(BASE_LOG2+code)` tick cycles. `code` is write bits [2:0]. Cycles with `tick` low do not count.
- R3: On timeout, `reset_req` is high for exactly one clock, in the cycle after the final tick. The count wraps to zero, so the next timeout needs a full period again.
- R4: A `kick` pulse sets the count to zero. It wins over a tick in the same cycle.
- R5: A write with bit 3 (enable) set switches the watchdog on at once, with no guard sequence. `cfg_rdata[3]` shows the enable state.
- R6: A write with bit 4 and bit 3 both set opens the turn-off window. `cfg_rdata[4]` reads 1 while the window is open.
- R7: A write with bit 3 clear switches the watchdog off if it arrives 1 to `WIN_CYCLES` (4) clocks after the opening write.
- R8: A clearing write outside the window leaves the watchdog on. The window closes by itself after `WIN_CYCLES` clocks, and `cfg_rdata[4]` then reads 0.
- R9: While the watchdog is off, ticks neither change the count nor raise `reset_req`. After it is switched on again without a kick, counting resumes from the kept value.
- R10: If the code is lowered below the current count, the next tick raises `reset_req` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_wdata | input | 5 | Write data: [4] turn-off-enable, [3] enable, [2:0] prescale code |
| cfg_rdata | output | 5 | Readback in the same layout; [4] shows whether the window is open |
| kick | input | 1 | Restart strobe that clears the count |
| tick | input | 1 | One-cycle watchdog time base pulse |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
A count that is off by one moves the `reset_req` pulse by one tick, so the bench counts the exact ticks up to the pulse for every prescale code. A window counter that is off by one shows up in the clearing write placed at offset 4 or 5, within five clocks of the opening write. A counter that changes while the watchdog is off is caught by the first timeout after it is switched back on. Checking the shortened timeout right after the code is lowered catches a prescale decode that is stale.

// File: rtl/wdog_pkg.sv
// Package: shared control-word layout for the watchdog.
// Assumes the control word is five bits wide, with fixed bit positions.
package wdog_pkg;
    localparam int PS_W   = 3;
    localparam int CODES  = 1 << PS_W;
    localparam int CTRL_W = PS_W + 2;

    typedef struct packed {
        logic            toe;   // turn-off-enable / window open
        logic            ena;   // watchdog on
        logic [PS_W-1:0] ps;    // prescale code
    } wdog_ctrl_t;
endpackage

// File: rtl/wdog_ctrl.sv
// Control register with a guarded turn-off.
// Setting enable is always accepted. Clearing it needs an open window,
// which a write with toe and ena both set opens for WIN_CYCLES clocks.
// Assumes cfg writes are synchronous one-cycle strobes.
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int WIN_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  wdog_ctrl_t wr_data,
    output wdog_ctrl_t ctrl_q
);
    localparam int WIN_W = $clog2(WIN_CYCLES + 1);
    localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WIN_CYCLES);

    logic [WIN_W-1:0] win_cnt;
    logic             ena_q;
    logic [PS_W-1:0]  ps_q;
    logic             win_open;

    assign win_open = (win_cnt != '0);

    // Enable and prescale: set freely, clear only inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q <= 1'b0;
            ps_q  <= '0;
        end else if (wr_en) begin
            ps_q <= wr_data.ps;
            if (wr_data.ena) begin
                ena_q <= 1'b1;
            end else if (win_open) begin
                ena_q <= 1'b0;
            end
        end
    end

    // Window timer: the opening write loads it, a disable closes it, otherwise it counts down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (wr_en && wr_data.ena && wr_data.toe) begin
            win_cnt <= WIN_LOAD;
        end else if (wr_en && !wr_data.ena && win_open) begin
            win_cnt <= '0;
        end else if (win_open) begin
            win_cnt <= win_cnt - WIN_W'(1);
        end
    end

    // Readback assembly.
    always_comb begin
        ctrl_q.toe = win_open;
        ctrl_q.ena = ena_q;
        ctrl_q.ps  = ps_q;
    end
endmodule

// File: rtl/wdog_limit.sv
// Timeout decode: turns the prescale code into a terminal tick count
// of 2^(BASE_LOG2+code). Assumes CNT_W > BASE_LOG2 + CODES - 1.
module wdog_limit
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 14,
    parameter int CNT_W     = BASE_LOG2 + CODES
) (
    input  logic [PS_W-1:0]  ps,
    output logic [CNT_W-1:0] limit
);
    logic [CNT_W-1:0] tbl [CODES];

    // One power-of-two entry per prescale code.
    for (genvar i = 0; i < CODES; i++) begin : g_code
        localparam int SH = BASE_LOG2 + i;
        assign tbl[i] = {{(CNT_W-1){1'b0}}, 1'b1} << SH;
    end

    // Select the entry for the current code.
    always_comb begin
        limit = tbl[ps];
    end
endmodule

// File: rtl/wdog_counter.sv
// Tick counter with restart and timeout.
// Counts ticks while enabled and holds its value while disabled.
// When count+1 reaches the limit, it wraps to zero and pulses expire for one clock.
// Uses >= so that lowering the limit below the count takes effect at once.
module wdog_counter #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ena,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] count_inc;

    assign count_inc = count + CNT_W'(1);

    // Count update; restart has priority over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            expire <= 1'b0;
        end else if (restart) begin
            count  <= '0;
            expire <= 1'b0;
        end else if (ena && tick) begin
            if (count_inc >= limit) begin
                count  <= '0;
                expire <= 1'b1;
            end else begin
                count  <= count_inc;
                expire <= 1'b0;
            end
        end else begin
            expire <= 1'b0;
        end
    end
endmodule

// File: rtl/wdog_top.sv
// Watchdog top level: joins the control register, the timeout decode and the counter.
// Assumes tick and kick are already synchronous to clk.
module wdog_top
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2  = 14,
    parameter int WIN_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    input  logic              kick,
    input  logic              tick,
    output logic              reset_req
);
    localparam int CNT_W = BASE_LOG2 + CODES;

    wdog_ctrl_t       ctrl_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] count_q;

    wdog_ctrl #(.WIN_CYCLES(WIN_CYCLES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (wdog_ctrl_t'(cfg_wdata)),
        .ctrl_q  (ctrl_q)
    );

    wdog_limit #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_limit (
        .ps    (ctrl_q.ps),
        .limit (limit)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ena     (ctrl_q.ena),
        .tick    (tick),
        .restart (kick),
        .limit   (limit),
        .count   (count_q),
        .expire  (reset_req)
    );

    assign cfg_rdata = ctrl_q;
endmodule

// File: rtl/wdog_top_chk.sv
// Checker bound to wdog_top: temporal properties over its ports and its count.
module wdog_top_chk #(
    parameter int CNT_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [4:0]       cfg_wdata,
    input logic [4:0]       cfg_rdata,
    input logic             kick,
    input logic             tick,
    input logic             reset_req,
    input logic [CNT_W-1:0] count_q
);
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reset_req |=> !reset_req); // R3
    AST_REQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) $rose(reset_req) |-> $past(tick && cfg_rdata[3] && !kick)); // R2
    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) kick |=> (count_q == '0)); // R4
    AST_ENA_SET_FREE: assert property (@(posedge clk) disable iff (!rst_n) (cfg_wr && cfg_wdata[3]) |=> cfg_rdata[3]); // R5
    AST_WIN_OPEN: assert property (@(posedge clk) disable iff (!rst_n) (cfg_wr && cfg_wdata[4] && cfg_wdata[3]) |=> cfg_rdata[4]); // R6
    AST_OFF_NEEDS_WIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(cfg_rdata[3]) |-> $past(cfg_rdata[4])); // R7
    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!cfg_rdata[3] && !kick) |=> $stable(count_q)); // R9
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !cfg_rdata[3] |=> !reset_req); // R9
endmodule

bind wdog_top wdog_top_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .kick      (kick),
    .tick      (tick),
    .reset_req (reset_req),
    .count_q   (count_q)
);

// File: tb/wdog_top_tb.sv
module wdog_top_tb;
    localparam int BASE = 2;
    localparam int WIN  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic [4:0] cfg_rdata;
    logic       kick = 1'b0;
    logic       tick = 1'b0;
    logic       reset_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdog_top #(.BASE_LOG2(BASE), .WIN_CYCLES(WIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .kick(kick), .tick(tick), .reset_req(reset_req)
    );

    function automatic int exp_limit(input int code);
        return 1 << (BASE + code);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] d);
        cfg_wr = 1'b1; cfg_wdata = d; cyc(); cfg_wr = 1'b0;
    endtask

    task automatic do_kick();
        kick = 1'b1; cyc(); kick = 1'b0;
    endtask

    task automatic do_tick();
        tick = 1'b1; cyc(); tick = 1'b0;
    endtask

    // n ticks with random gaps: quiet for n-1, pulse on the n-th, low one cycle later
    task automatic run_period(input int n, input string req, input bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps) repeat ($urandom % 3) begin
                cyc();
                if (reset_req) chk(1'b0, req, 1, 0);
            end
            do_tick();
            if (i < n - 1) begin
                if (reset_req) chk(1'b0, req, 1, 0);
            end else begin
                chk(reset_req == 1'b1, req, int'(reset_req), 1);
            end
        end
        cyc();
        chk(reset_req == 1'b0, "R3", int'(reset_req), 0);
    endtask

    task automatic open_and_clear(input int gap);
        wr(5'b11000);
        chk(cfg_rdata[4] == 1'b1, "R6", int'(cfg_rdata[4]), 1);
        repeat (gap - 1) cyc();
        wr(5'b00000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        chk(cfg_rdata == 5'd0, "R1", int'(cfg_rdata), 0);
        chk(reset_req == 1'b0, "R1", int'(reset_req), 0);

        // R1: count is zero out of reset, so the first period is full
        wr(5'b01000);
        chk(cfg_rdata[3] == 1'b1, "R5", int'(cfg_rdata[3]), 1);
        run_period(exp_limit(0), "R1", 1'b0);

        // R2: every prescale code, R3: back-to-back periods for small codes
        for (int c = 0; c < 8; c++) begin
            wr(5'(8 + c));
            do_kick();
            run_period(exp_limit(c), "R2", 1'b0);
            if (c < 2) run_period(exp_limit(c), "R3", 1'b0);
        end

        // R4: kick at the same time as a tick clears the count
        wr(5'b01000); do_kick();
        do_tick(); do_tick();
        kick = 1'b1; tick = 1'b1; cyc(); kick = 1'b0; tick = 1'b0;
        run_period(exp_limit(0), "R4", 1'b0);

        // R7: clearing write at every offset inside the window
        for (int d = 1; d <= WIN; d++) begin
            wr(5'b01000);
            open_and_clear(d);
            chk(cfg_rdata[3] == 1'b0, "R7", int'(cfg_rdata[3]), 0);
        end

        // R8: clearing write one cycle too late, with no opening write, and toe set without ena
        wr(5'b01000);
        open_and_clear(WIN + 1);
        chk(cfg_rdata[3] == 1'b1, "R8", int'(cfg_rdata[3]), 1);
        chk(cfg_rdata[4] == 1'b0, "R8", int'(cfg_rdata[4]), 0);
        wr(5'b00000);
        chk(cfg_rdata[3] == 1'b1, "R8", int'(cfg_rdata[3]), 1);
        wr(5'b10000);
        chk(cfg_rdata[3] == 1'b1, "R8", int'(cfg_rdata[3]), 1);

        // R9: count held while off; resumes without kick
        wr(5'b01000); do_kick();
        do_tick(); do_tick();
        open_and_clear(2);
        chk(cfg_rdata[3] == 1'b0, "R9", int'(cfg_rdata[3]), 0);
        for (int i = 0; i < 10; i++) begin
            do_tick();
            if (reset_req) chk(1'b0, "R9", 1, 0);
        end
        wr(5'b01000);
        run_period(exp_limit(0) - 2, "R9", 1'b0);

        // R10: lowering the code below the count gives an early timeout
        wr(5'b01011); do_kick();
        for (int i = 0; i < 20; i++) do_tick();
        chk(reset_req == 1'b0, "R10", int'(reset_req), 0);
        wr(5'b01001);
        do_tick();
        chk(reset_req == 1'b1, "R10", int'(reset_req), 1);

        // R2: random codes with random gaps between ticks
        for (int k = 0; k < 8; k++) begin
            int c;
            c = int'($urandom % 5);
            wr(5'(8 + c));
            do_kick();
            run_period(exp_limit(c), "R2", 1'b1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule